// File: doc/BRIEF.md
# Four-Operation Nibble ALU

This block is a purely combinational arithmetic logic unit for two 4-bit operands. A 2-bit opcode picks one of four operations: bitwise NAND, bitwise OR, addition or subtraction. The picked value appears on the result port, along with three flags: carry, zero and signed overflow.

The design has two units. The logic unit makes NAND or OR. The arithmetic unit is a single ripple-carry adder built from identical one-bit slices; only the carry passes from slice to slice. For subtraction, the adder inverts B and sets the incoming carry to one. Opcode bit 0 picks the operation inside each unit, and opcode bit 1 picks which unit drives the result. Both unit outputs also appear together on a wide observation port, so the logic value and the arithmetic value can be read at the same time.

There is no clock and no storage. Every output follows the inputs after the combinational delay.

Top module: `nibble_alu`

## Requirements
- R1: With opcode 2'b00, the result is the bitwise NAND of A and B.
- R2: With opcode 2'b01, the result is the bitwise OR of A and B.
- R3: With opcode 2'b10, the result is (A + B) mod 16, and the carry flag is bit 4 of the unsigned sum A + B.
- R4: With opcode 2'b11, the result is (A - B) mod 16, and the carry flag is 1 exactly when A >= B as unsigned values (1 means no borrow).
- R5: The observation port always carries the logic-unit value in bits [7:4] and the arithmetic-unit value in bits [3:0]. Both values follow opcode bit 0 only: NAND and sum when it is 0, OR and difference when it is 1. Opcode bit 1 has no effect on this port.
- R6: The zero flag is 1 exactly when the 4-bit result is 0000.
- R7: The overflow flag is 1 for opcodes 2'b10 and 2'b11 exactly when the two's-complement value of the operation falls outside -8..7. For opcodes 2'b00 and 2'b01 it is 0.
- R8: The carry flag is 0 for opcodes 2'b00 and 2'b01.
- R9: The result equals bits [7:4] of the observation port when opcode bit 1 is 0, and bits [3:0] when opcode bit 1 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | Operand A |
| b_i | input | 4 | Operand B |
| op_i | input | 2 | Operation select |
| result_o | output | 4 | Selected result |
| carry_o | output | 1 | Adder carry out (no-borrow flag for subtraction) |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow of the arithmetic operations |
| units_o | output | 8 | Logic-unit value in [7:4], arithmetic-unit value in [3:0] |

## Verification
Every output is due in the same cycle as its stimulus, because no register lies between the inputs and the outputs. The bench applies each operand and opcode combination just after a rising edge of its clock. It reads all outputs at the following falling edge, when the ripple chain has had half a period to settle, so each check compares values that were all produced by a single input set. The sweep covers all 1024 combinations, including operands that equal each other, all-ones carry chains and the signed limits of -8 and 7.

// File: rtl/nibble_alu_pkg.sv
package nibble_alu_pkg;

   typedef enum logic [1:0] {
      OP_NAND = 2'b00,
      OP_OR   = 2'b01,
      OP_ADD  = 2'b10,
      OP_SUB  = 2'b11
   } alu_op_e;

   localparam int unsigned MIN_WIDTH = 2;

endpackage

// File: rtl/nibble_alu_slice.sv
// One bit of the arithmetic unit: a full adder with an optional operand invert.
module nibble_alu_slice (
   input  logic a_i,
   input  logic b_i,
   input  logic inv_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);
   logic b_eff;
   logic half;

   always_comb begin
      b_eff = b_i ^ inv_i;
      half  = a_i ^ b_eff;
      s_o   = half ^ c_i;
      c_o   = (a_i & b_eff) | (half & c_i);
   end
endmodule

// File: rtl/nibble_alu_arith.sv
// Ripple-carry arithmetic unit. sub_i inverts B and injects the first carry.
module nibble_alu_arith #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   output logic [W-1:0] y_o,
   output logic         cout_o,
   output logic         ovf_o
);
   import nibble_alu_pkg::*;

   localparam int unsigned CW = W + 1;

   logic [CW-1:0] chain;

   initial begin
      if (W < MIN_WIDTH) $fatal(1, "nibble_alu_arith: W must be at least %0d", MIN_WIDTH);
   end

   assign chain[0] = sub_i;

   for (genvar i = 0; i < W; i++) begin : g_slice
      nibble_alu_slice u_slice (
         .a_i  (a_i[i]),
         .b_i  (b_i[i]),
         .inv_i(sub_i),
         .c_i  (chain[i]),
         .s_o  (y_o[i]),
         .c_o  (chain[i+1])
      );
   end

   assign cout_o = chain[W];
   // Signed overflow: the carry into the sign slice differs from the carry out of it.
   assign ovf_o  = chain[W] ^ chain[W-1];

   // The ripple chain must match the word-level sum of the same operands.
   always_comb begin
      assert_chain_sum_R3: assert (sub_i ||
         ({cout_o, y_o} == ({1'b0, a_i} + {1'b0, b_i})))
         else $error("ripple sum mismatch");
      assert_chain_diff_R4: assert (!sub_i ||
         ({cout_o, y_o} == ({1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, 1'b1})))
         else $error("ripple difference mismatch");
   end
endmodule

// File: rtl/nibble_alu_logic.sv
// Logic unit: per-bit NAND or OR, chosen by sel_or_i.
module nibble_alu_logic #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sel_or_i,
   output logic [W-1:0] y_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic nand_b;
      logic or_b;
      always_comb begin
         nand_b = ~(a_i[i] & b_i[i]);
         or_b   = a_i[i] | b_i[i];
         y_o[i] = sel_or_i ? or_b : nand_b;
      end
   end

   always_comb begin
      // NAND: no bit may be high where both operands are high, and every other bit must be high.
      assert_nand_R1: assert (sel_or_i || (((y_o & a_i & b_i) == '0) && ((y_o | (a_i & b_i)) == '1)))
         else $error("NAND bits wrong");
      // OR: every set operand bit is set, and nothing else is.
      assert_or_R2: assert (!sel_or_i || ((((a_i | b_i) & ~y_o) == '0) && ((y_o & ~(a_i | b_i)) == '0)))
         else $error("OR bits wrong");
   end
endmodule

// File: rtl/nibble_alu.sv
module nibble_alu #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0]   a_i,
   input  logic [W-1:0]   b_i,
   input  logic [1:0]     op_i,
   output logic [W-1:0]   result_o,
   output logic           carry_o,
   output logic           zero_o,
   output logic           ovf_o,
   output logic [2*W-1:0] units_o
);
   import nibble_alu_pkg::*;

   localparam int unsigned UW = 2 * W;

   alu_op_e     op;
   logic [W-1:0] logic_y;
   logic [W-1:0] arith_y;
   logic        arith_c;
   logic        arith_v;
   logic        arith_sel;

   initial begin
      if (W < MIN_WIDTH) $fatal(1, "nibble_alu: W must be at least %0d", MIN_WIDTH);
      if (UW != 2 * W)   $fatal(1, "nibble_alu: observation width inconsistent");
   end

   assign op        = alu_op_e'(op_i);
   assign arith_sel = (op == OP_ADD) || (op == OP_SUB);

   nibble_alu_logic #(.W(W)) u_logic (
      .a_i     (a_i),
      .b_i     (b_i),
      .sel_or_i(op_i[0]),
      .y_o     (logic_y)
   );

   nibble_alu_arith #(.W(W)) u_arith (
      .a_i   (a_i),
      .b_i   (b_i),
      .sub_i (op_i[0]),
      .y_o   (arith_y),
      .cout_o(arith_c),
      .ovf_o (arith_v)
   );

   assign units_o  = {logic_y, arith_y};
   assign result_o = arith_sel ? arith_y : logic_y;
   assign carry_o  = arith_sel & arith_c;
   assign ovf_o    = arith_sel & arith_v;
   assign zero_o   = ~|result_o;

   always_comb begin
      assert_zero_R6: assert (zero_o == (result_o == '0))
         else $error("zero flag disagrees with result");
      assert_logic_no_ovf_R7: assert (op_i[1] || !ovf_o)
         else $error("overflow raised for a logic operation");
      assert_logic_no_carry_R8: assert (op_i[1] || !carry_o)
         else $error("carry raised for a logic operation");
      assert_select_R9: assert (result_o == (op_i[1] ? units_o[W-1:0] : units_o[UW-1:W]))
         else $error("result does not follow selected unit");
   end
endmodule

// File: tb/tb_nibble_alu.sv
module tb_nibble_alu;
   logic       clk;
   logic [3:0] a;
   logic [3:0] b;
   logic [1:0] op;
   logic [3:0] res;
   logic       cy;
   logic       zf;
   logic       vf;
   logic [7:0] units;
   int         checks;
   int         errors;
   logic       done;

   nibble_alu #(.W(4)) dut (
      .a_i(a), .b_i(b), .op_i(op),
      .result_o(res), .carry_o(cy), .zero_o(zf), .ovf_o(vf), .units_o(units)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;  // 50 MHz

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: a=%0d b=%0d op=%0d actual=%0d expected=%0d",
                  tag, what, a, b, op, act, exp);
      end
   endtask

   function automatic int sval(input int v);
      return (v >= 8) ? v - 16 : v;
   endfunction

   initial begin
      done = 1'b0;
      checks = 0;
      errors = 0;
      a = 4'd0; b = 4'd0; op = 2'b00;
      @(negedge clk);
      // Settled state with every input at zero: NAND gives all ones.
      check("R1", "idle result", int'(res), 15);
      check("R6", "idle zero", int'(zf), 0);
      check("R8", "idle carry", int'(cy), 0);
      for (int o = 0; o < 4; o++) begin
         for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
               int e_nand, e_or, e_sum, e_dif, e_res, e_c, e_v, e_lu, e_au, s;
               @(posedge clk);
               #1;
               a = 4'(x); b = 4'(y); op = 2'(o);
               @(negedge clk);
               e_nand = (~(x & y)) & 15;
               e_or   = (x | y) & 15;
               e_sum  = (x + y) & 15;
               e_dif  = (x - y + 16) & 15;
               e_lu   = (o % 2 == 0) ? e_nand : e_or;
               e_au   = (o % 2 == 0) ? e_sum : e_dif;
               e_c = 0; e_v = 0;
               case (o)
                  0: begin e_res = e_nand; check("R1", "nand", int'(res), e_res); end
                  1: begin e_res = e_or;   check("R2", "or", int'(res), e_res); end
                  2: begin
                     e_res = e_sum;
                     e_c = ((x + y) >= 16) ? 1 : 0;
                     s = sval(x) + sval(y);
                     e_v = (s > 7 || s < -8) ? 1 : 0;
                     check("R3", "sum", int'(res), e_res);
                     check("R3", "sum carry", int'(cy), e_c);
                  end
                  default: begin
                     e_res = e_dif;
                     e_c = (x >= y) ? 1 : 0;
                     s = sval(x) - sval(y);
                     e_v = (s > 7 || s < -8) ? 1 : 0;
                     check("R4", "difference", int'(res), e_res);
                     check("R4", "no-borrow", int'(cy), e_c);
                  end
               endcase
               if (o < 2) check("R8", "logic carry", int'(cy), 0);
               check("R7", "overflow", int'(vf), e_v);
               check("R6", "zero", int'(zf), (e_res == 0) ? 1 : 0);
               check("R5", "units", int'(units), e_lu * 16 + e_au);
               check("R9", "selection", int'(res), (o >= 2) ? int'(units[3:0]) : int'(units[7:4]));
            end
         end
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule